// File: doc/BRIEF.md
# EDO Read Sample Delay Calculator

This block derives the interface timing settings for the two fastest asynchronous NAND timing modes (mode 4 and mode 5) from the period of the interface clock. The period arrives in tenths of a nanosecond, together with a mode select and a bit that picks the lower of two reference-period thresholds. A one-cycle start pulse captures the inputs. An internal restoring divider then runs one quotient bit per cycle. When it finishes, the block registers its outputs and raises a one-cycle done pulse.

The outputs are the strobe setup, hold and address-setup counts, the fixed busy timeout, a half-period flag and the read-sample delay code. The delay code sets how far the sampling strobe fed back from the read-enable pin is delayed, counted in eighths of the reference period. The reference period is either the clock period or half of it. The code is worked out with all times scaled by ten, then rounded to the nearest integer and clamped to the code field. The results stay on the outputs until the next calculation completes.

Top module: `edo_delay_calc`

## Requirements
- R1: After reset, done is 0 and every result output (setup, hold, address setup, busy timeout, half-period flag, delay code) is 0.
- R2: The inputs are captured on the clock edge where start is 1 and no calculation is running. done is then 1 for exactly one cycle, 16 edges later with default parameters (divider width plus one). Input changes after the capturing edge do not alter the result.
- R3: After a completed calculation, data setup is 1, data hold is 1 and busy timeout is 0x9000.
- R4: Address setup is 1 when the mode select is 1 (mode 5) and 0 when it is 0 (mode 4).
- R5: The threshold is 160 tenths of a ns when the threshold select is 0 and 120 when it is 1. The half-period flag is 1 exactly when the period is strictly greater than the threshold.
- R6: The reference period RP is the clock period P (in tenths of a ns), or floor(P/2) when the half-period flag is 1.
- R7: With access time A = 160 for mode 5 or 200 for mode 4, and adjustment 40 (all in tenths of a ns), the quotient q = floor((A + 40 − P) × 80 / RP). The delay code is floor((q + 5) / 10).
- R8: When A + 40 − P is zero or negative, the delay code is 0.
- R9: When the rounded value exceeds 15, or RP is 0 with a positive numerator, the delay code is 15.
- R10: A start pulse while a calculation is running is ignored. Neither the result nor the time of done changes, and the outputs hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; captures the inputs when idle |
| period_dns | input | PERIOD_W (12) | Interface clock period in tenths of a ns |
| mode5_sel | input | 1 | 1 selects mode 5, 0 selects mode 4 |
| alt_thr_sel | input | 1 | 1 selects the 12 ns threshold, 0 the 16 ns one |
| done | output | 1 | One-cycle pulse when the results are updated |
| data_setup | output | CNT_W (4) | Data setup count |
| data_hold | output | CNT_W (4) | Data hold count |
| addr_setup | output | CNT_W (4) | Address setup count |
| busy_timeout | output | BUSY_W (16) | Ready/busy timeout value |
| half_period | output | 1 | Reference period is half the clock period |
| delay_code | output | DLY_W (4) | Read-sample delay in eighths of RP |

## Verification
Directed periods on both sides of each threshold (160/161 and 120/121) separate the strict greater-than compare from greater-or-equal, and confirm that the threshold select is honoured. Periods of 0 and 1 drive RP to 0 and 1 and exercise upper saturation. Periods above the access time plus adjustment exercise the clamp at zero. Known points such as 10 ns in mode 5 (code 8) and 20 ns in mode 4 (code 3) check the rounding. Random periods, modes and thresholds, with the inputs scrambled after capture and some extra start pulses during a run, check R2 and R10.

// File: rtl/edo_calc_pkg.sv
package edo_calc_pkg;
   // all times in tenths of a nanosecond
   localparam int T_REA_M5  = 160;
   localparam int T_REA_M4  = 200;
   localparam int ADJ_C     = 40;
   localparam int THR_STD   = 160;
   localparam int THR_ALT   = 120;
   localparam int DLY_STEPS = 8;
   localparam int SCALE     = 10;
   localparam int BUSY_TMO  = 16'h9000;
   localparam int MAX_BASE  = T_REA_M4 + ADJ_C;
   localparam int DVD_MAX   = MAX_BASE * DLY_STEPS * SCALE;

   typedef struct packed {
      logic mode5;
      logic half;
   } edo_cfg_t;
endpackage

// File: rtl/edo_operand_prep.sv
module edo_operand_prep
   import edo_calc_pkg::*;
#(
   parameter int PERIOD_W = 12,
   parameter int DVD_W    = 15
) (
   input  logic [PERIOD_W-1:0] period,
   input  logic                mode5,
   input  logic                alt_thr,
   output logic                half,
   output logic [PERIOD_W-1:0] rp,
   output logic [DVD_W-1:0]    dividend
);
   localparam logic [DVD_W-1:0] MULT = DVD_W'(DLY_STEPS * SCALE);

   logic [PERIOD_W-1:0] thr;
   logic [PERIOD_W-1:0] base;

   always_comb begin
      thr  = alt_thr ? PERIOD_W'(THR_ALT) : PERIOD_W'(THR_STD);
      base = mode5 ? PERIOD_W'(T_REA_M5 + ADJ_C) : PERIOD_W'(T_REA_M4 + ADJ_C);
      half = (period > thr);
      rp   = half ? (period >> 1) : period;
      if (period < base)
         dividend = DVD_W'(base - period) * MULT;
      else
         dividend = '0;
   end
endmodule

// File: rtl/edo_serial_divider.sv
module edo_serial_divider #(
   parameter int DVD_W = 15,
   parameter int DVS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             busy,
   output logic             fin,
   output logic [DVD_W-1:0] quotient
);
   localparam int CNT_W = $clog2(DVD_W + 1);

   logic [DVS_W:0]   rem_q;
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DVS_W:0]   shifted;
   logic [DVS_W:0]   trial;
   logic             fits;

   always_comb begin
      shifted = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
      trial   = shifted - {1'b0, dvs_q};
      fits    = (shifted >= {1'b0, dvs_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         quo_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load && !busy) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CNT_W'(DVD_W);
            busy  <= 1'b1;
         end else if (busy) begin
            rem_q <= fits ? trial : shifted;
            quo_q <= {quo_q[DVD_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy <= 1'b0;
               fin  <= 1'b1;
            end
         end
      end
   end

   assign quotient = quo_q;

   // R2
   fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
   // R2
   fin_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> ($past(busy) && !busy));
endmodule

// File: rtl/edo_round_sat.sv
module edo_round_sat #(
   parameter int Q_W   = 15,
   parameter int DLY_W = 4
) (
   input  logic [Q_W-1:0]   quot,
   output logic [DLY_W-1:0] code
);
   localparam int SUM_W = Q_W + 1;
   localparam logic [SUM_W-1:0] LIM  = SUM_W'((2 ** DLY_W) * 10);
   localparam logic [SUM_W-1:0] TEN  = SUM_W'(10);
   localparam logic [SUM_W-1:0] HALF = SUM_W'(5);

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = {1'b0, quot} + HALF;
      if (sum >= LIM)
         code = '1;
      else
         code = DLY_W'(sum / TEN);
   end
endmodule

// File: rtl/edo_delay_calc.sv
module edo_delay_calc
   import edo_calc_pkg::*;
#(
   parameter int PERIOD_W = 12,
   parameter int CNT_W    = 4,
   parameter int BUSY_W   = 16,
   parameter int DLY_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PERIOD_W-1:0] period_dns,
   input  logic                mode5_sel,
   input  logic                alt_thr_sel,
   output logic                done,
   output logic [CNT_W-1:0]    data_setup,
   output logic [CNT_W-1:0]    data_hold,
   output logic [CNT_W-1:0]    addr_setup,
   output logic [BUSY_W-1:0]   busy_timeout,
   output logic                half_period,
   output logic [DLY_W-1:0]    delay_code
);
   localparam int DVD_W = $clog2(DVD_MAX + 1);

   initial begin
      if (PERIOD_W < 8) $error("PERIOD_W must hold the access-time base");
      if (BUSY_W < 16) $error("BUSY_W too narrow for the busy timeout");
      if (CNT_W < 1 || DLY_W < 1) $error("count widths must be positive");
   end

   logic                accept;
   logic                run;
   logic                div_busy;
   logic                div_fin;
   logic                prep_half;
   logic [PERIOD_W-1:0] prep_rp;
   logic [DVD_W-1:0]    prep_dvd;
   logic [DVD_W-1:0]    quot;
   logic [DLY_W-1:0]    code_nxt;
   edo_cfg_t            cfg_q;

   assign accept = start && !run;

   edo_operand_prep #(.PERIOD_W(PERIOD_W), .DVD_W(DVD_W)) prep_i (
      .period   (period_dns),
      .mode5    (mode5_sel),
      .alt_thr  (alt_thr_sel),
      .half     (prep_half),
      .rp       (prep_rp),
      .dividend (prep_dvd)
   );

   edo_serial_divider #(.DVD_W(DVD_W), .DVS_W(PERIOD_W)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .dividend (prep_dvd),
      .divisor  (prep_rp),
      .busy     (div_busy),
      .fin      (div_fin),
      .quotient (quot)
   );

   edo_round_sat #(.Q_W(DVD_W), .DLY_W(DLY_W)) rnd_i (
      .quot (quot),
      .code (code_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run          <= 1'b0;
         cfg_q        <= '0;
         done         <= 1'b0;
         data_setup   <= '0;
         data_hold    <= '0;
         addr_setup   <= '0;
         busy_timeout <= '0;
         half_period  <= 1'b0;
         delay_code   <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            run         <= 1'b1;
            cfg_q.mode5 <= mode5_sel;
            cfg_q.half  <= prep_half;
         end else if (div_fin) begin
            run          <= 1'b0;
            done         <= 1'b1;
            data_setup   <= CNT_W'(1);
            data_hold    <= CNT_W'(1);
            addr_setup   <= CNT_W'(cfg_q.mode5);
            busy_timeout <= BUSY_W'(BUSY_TMO);
            half_period  <= cfg_q.half;
            delay_code   <= code_nxt;
         end
      end
   end

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !div_fin) |=> !done);
   // R2
   div_inside_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> run);
   // R3
   fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (data_setup == CNT_W'(1) && data_hold == CNT_W'(1)
                && busy_timeout == BUSY_W'(BUSY_TMO)));
   // R10
   hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(delay_code) && $stable(half_period)));
endmodule

// File: tb/edo_delay_calc_tb_top.sv
module edo_delay_calc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] period_dns = '0;
   logic        mode5_sel = 1'b0;
   logic        alt_thr_sel = 1'b0;
   logic        done;
   logic [3:0]  data_setup, data_hold, addr_setup;
   logic [15:0] busy_timeout;
   logic        half_period;
   logic [3:0]  delay_code;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   edo_delay_calc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .period_dns(period_dns),
      .mode5_sel(mode5_sel), .alt_thr_sel(alt_thr_sel), .done(done),
      .data_setup(data_setup), .data_hold(data_hold), .addr_setup(addr_setup),
      .busy_timeout(busy_timeout), .half_period(half_period),
      .delay_code(delay_code)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_half(input int p, input bit a);
      int thr = a ? 120 : 160;
      return p > thr;
   endfunction

   function automatic int exp_code(input int p, input bit m, input bit a);
      int rp, num, q, r;
      rp  = exp_half(p, a) ? p / 2 : p;
      num = (m ? 160 : 200) + 40 - p;
      if (num <= 0) return 0;
      if (rp == 0) return 15;
      q = (num * 80) / rp;
      r = (q + 5) / 10;
      return (r > 15) ? 15 : r;
   endfunction

   task automatic run_case(input int p, input bit m, input bit a, input bit disturb);
      int ec = exp_code(p, m, a);
      int eh = exp_half(p, a);
      @(negedge clk);
      period_dns = 12'(p); mode5_sel = m; alt_thr_sel = a; start = 1'b1;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         period_dns = 12'($urandom); mode5_sel = 1'($urandom); alt_thr_sel = 1'($urandom);
         if (disturb && k == 5) start = 1'b1;
         if (k == 6) start = 1'b0;
         if (k == 16) chk(done == 1'b0, "R2", "done early", done, 0);
      end
      @(negedge clk);
      chk(done == 1'b1, "R2", "done at latency", done, 1);
      chk(delay_code == 4'(ec), "R7", $sformatf("code p=%0d m=%0d a=%0d", p, m, a), delay_code, ec);
      chk(half_period == 1'(eh), "R5", "half flag", half_period, eh);
      chk(addr_setup == 4'(m), "R4", "addr setup", addr_setup, m);
      chk(data_setup == 4'd1 && data_hold == 4'd1, "R3", "setup/hold",
          {data_setup, data_hold}, 8'h11);
      chk(busy_timeout == 16'h9000, "R3", "busy timeout", busy_timeout, 16'h9000);
      @(negedge clk);
      chk(done == 1'b0 && delay_code == 4'(ec), "R10", "hold after done",
          {done, delay_code}, ec);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(done == 0 && delay_code == 0 && half_period == 0 && data_setup == 0
          && data_hold == 0 && addr_setup == 0 && busy_timeout == 0,
          "R1", "reset outputs", {done, delay_code}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 0 && busy_timeout == 0, "R1", "idle after reset", done, 0);
      // directed points
      run_case(100, 1, 0, 0);  // R7: code 8
      run_case(200, 0, 0, 0);  // R6 R7: half, rp 100, code 3
      run_case(125, 0, 1, 1);  // R10 disturbed; R5 alt threshold
      run_case(160, 1, 0, 0);  // R5 boundary, no half
      run_case(161, 1, 0, 0);  // R5 boundary, half
      run_case(120, 0, 1, 0);  // R5
      run_case(121, 0, 1, 0);  // R5
      run_case(250, 1, 0, 0);  // R8 negative numerator
      run_case(240, 0, 0, 0);  // R8 zero numerator
      run_case(4095, 0, 1, 0); // R8
      run_case(1, 0, 0, 0);    // R9 rp 1
      run_case(0, 1, 1, 0);    // R9 rp 0
      for (int i = 0; i < 40; i++) begin
         int p = (i % 5 == 4) ? int'($urandom % 4096) : int'($urandom % 300);
         run_case(p, 1'($urandom), 1'($urandom), 1'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule